// File: doc/BRIEF.md
# Ethernet Transmit Error Supervisor

This block sits beside a byte-wide Ethernet transmit serializer and decides how each frame ends. It follows the frame through carrier sense, collision, the per-byte FIFO state and the retry count. For every frame that closes, it produces a one-cycle descriptor write carrying five status flags: underrun, carrier lost, retry limit, late collision and heartbeat missing.

Errors fall into two classes. A fatal error is an underrun, an exhausted retry budget or a late collision. It aborts the frame and halts the supervisor until a restart command arrives. A non-fatal error is a lost carrier or a missing heartbeat. It only flags status, and the frame completes. On an underrun the block first asks the serializer to send 32 corrupted CRC bits, the complement of the good CRC, so that the receiving station rejects the frame. After a clean frame end with heartbeat checking enabled, the block waits a fixed window for the transceiver's collision-style health pulse.

Any closing frame that carries an error flag sets a sticky transmit-error event. Writing 1 clears the event. The interrupt output is the event ANDed with its mask. Software normally programs a retry limit of 15 and a late-collision window of 64 bytes.

Top module: `eth_tx_err_sup`

## Requirements
- R1: A frame that ends (tx_active_i sampled low) with no fault and heartbeat checking off produces a one-cycle desc_wr_o in the next cycle, with all five status bits 0 and no event.
- R2: When byte_tick_i and fifo_empty_i are sampled together during a frame, force_bad_crc_o rises in the next cycle and stays high for exactly 4 further byte ticks (32 bits). The frame then closes with abort_o, desc_un_o and the event set.
- R3: After an underrun, retry-limit or late-collision close, halted_o is 1. While halted, new frames produce no descriptor write. A restart_i pulse clears halted_o in the next cycle.
- R4: When crs_i is low in any cycle of a frame that sees no collision, the frame closes normally with desc_csl_o set and the event raised. There is no abort and no halt.
- R5: A collision before the late window with retry_cnt_i below retry_lim_i writes no descriptor, does not abort, and returns to idle to wait for the retried attempt.
- R6: A collision before the late window with retry_cnt_i at or above retry_lim_i closes the frame with desc_rl_o, abort_o and the event.
- R7: A collision when the count of bytes sent is at least late_win_i closes the frame with desc_lc_o, abort_o and the event. One byte fewer is an ordinary collision.
- R8: With hb_en_i set, a col_i sampled in any of the 20 cycles after the frame end closes the frame in the next cycle with desc_hb_o 0 and no abort.
- R9: With hb_en_i set and no col_i in those 20 cycles, the frame closes after the 20th cycle with desc_hb_o 1 and the event, without halting.
- R10: txe_evt_o is sticky and is cleared by evt_clr_i. A new error in the same cycle as a clear leaves it set.
- R11: txe_irq_o is 1 exactly when txe_evt_o is 1 and evt_mask_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_active_i | input | 1 | Serializer is sending a frame |
| byte_tick_i | input | 1 | One byte leaves the serializer this cycle |
| fifo_empty_i | input | 1 | Transmit FIFO has no data |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision or heartbeat indication |
| retry_cnt_i | input | RETRY_W | Attempts already made for this frame |
| retry_lim_i | input | RETRY_W | Retry limit |
| late_win_i | input | CNT_W | Late-collision window in bytes |
| hb_en_i | input | 1 | Heartbeat check enable |
| restart_i | input | 1 | Restart-transmit command pulse |
| evt_clr_i | input | 1 | Write-1 clear of the error event |
| evt_mask_i | input | 1 | Interrupt mask for the event |
| force_bad_crc_o | output | 1 | Serializer sends the inverted CRC |
| abort_o | output | 1 | Abort-frame strobe |
| desc_wr_o | output | 1 | Descriptor status write strobe |
| desc_un_o | output | 1 | Underrun status bit |
| desc_csl_o | output | 1 | Carrier-lost status bit |
| desc_rl_o | output | 1 | Retry-limit status bit |
| desc_lc_o | output | 1 | Late-collision status bit |
| desc_hb_o | output | 1 | Heartbeat-missing status bit |
| txe_evt_o | output | 1 | Sticky transmit-error event |
| txe_irq_o | output | 1 | Masked event interrupt |
| halted_o | output | 1 | Transmission halted |

## Verification
Two functions can fall in the same cycle. A frame closing with an error sets the sticky event, and software may clear that event in that very cycle. To provoke this, the bench drives evt_clr_i in the cycle where a carrier-lost frame ends, while the event is already high. The check then expects the event to stay set, and expects a lone clear in the next test cycle to drop it. A second same-cycle case is a collision at the heartbeat window's last cycle. It must count as a good heartbeat, not as an expiry.

// File: rtl/eth_txs_pkg.sv
package eth_txs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_JAM,
    ST_HBW,
    ST_HALT
  } txs_state_e;

  typedef struct packed {
    logic un;
    logic csl;
    logic rl;
    logic lc;
    logic hb;
  } txs_stat_t;
endpackage

// File: rtl/eth_txs_cnt.sv
module eth_txs_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && (cnt_o != '1))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/eth_txs_evt.sv
module eth_txs_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic evt_o,
  output logic irq_o
);
  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= 1'b0;
    else         evt_o <= (evt_o & ~clr_i) | set_i;
  end

  assign irq_o = evt_o & mask_i;
endmodule

// File: rtl/eth_txs_fsm.sv
module eth_txs_fsm
  import eth_txs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RETRY_W   = 4,
  parameter int HB_WIN    = 20,
  parameter int JAM_BYTES = 4,
  localparam int HB_W     = $clog2(HB_WIN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_active_i,
  input  logic               byte_tick_i,
  input  logic               fifo_empty_i,
  input  logic               crs_i,
  input  logic               col_i,
  input  logic [RETRY_W-1:0] retry_cnt_i,
  input  logic [RETRY_W-1:0] retry_lim_i,
  input  logic [CNT_W-1:0]   late_win_i,
  input  logic               hb_en_i,
  input  logic               restart_i,
  input  logic [CNT_W-1:0]   byte_cnt_i,
  input  logic [HB_W-1:0]    hb_cnt_i,
  output logic               byte_clr_o,
  output logic               byte_inc_o,
  output logic               hb_clr_o,
  output logic               hb_inc_o,
  output logic               force_bad_crc_o,
  output logic               abort_o,
  output logic               desc_wr_o,
  output txs_stat_t          stat_o,
  output logic               evt_set_o,
  output logic               halted_o
);
  localparam logic [CNT_W-1:0] JAM_LAST = CNT_W'(JAM_BYTES - 1);
  localparam logic [HB_W-1:0]  HB_LAST  = HB_W'(HB_WIN - 1);

  txs_state_e state_q, state_d;
  logic       csl_q, csl_d;
  logic       close_c, fatal_c;
  txs_stat_t  stat_c;

  always_comb begin
    state_d    = state_q;
    csl_d      = csl_q;
    close_c    = 1'b0;
    fatal_c    = 1'b0;
    stat_c     = '0;
    byte_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        byte_clr_o = 1'b1;
        csl_d      = 1'b0;
        if (tx_active_i) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (!crs_i) csl_d = 1'b1;
        if (col_i) begin
          if (byte_cnt_i >= late_win_i) begin
            close_c   = 1'b1;
            fatal_c   = 1'b1;
            stat_c.lc = 1'b1;
            state_d   = ST_HALT;
          end else if (retry_cnt_i >= retry_lim_i) begin
            close_c   = 1'b1;
            fatal_c   = 1'b1;
            stat_c.rl = 1'b1;
            state_d   = ST_HALT;
          end else begin
            state_d = ST_IDLE;  // serializer retries after backoff
          end
        end else if (byte_tick_i && fifo_empty_i) begin
          byte_clr_o = 1'b1;    // counter reused for the 32 jam bits
          state_d    = ST_JAM;
        end else if (!tx_active_i) begin
          if (hb_en_i) begin
            state_d = ST_HBW;
          end else begin
            close_c    = 1'b1;
            stat_c.csl = csl_q | ~crs_i;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_JAM: begin
        if (byte_tick_i && (byte_cnt_i == JAM_LAST)) begin
          close_c   = 1'b1;
          fatal_c   = 1'b1;
          stat_c.un = 1'b1;
          state_d   = ST_HALT;
        end
      end
      ST_HBW: begin
        if (col_i) begin
          close_c    = 1'b1;
          stat_c.csl = csl_q;
          state_d    = ST_IDLE;
        end else if (hb_cnt_i == HB_LAST) begin
          close_c    = 1'b1;
          stat_c.csl = csl_q;
          stat_c.hb  = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_HALT: begin
        if (restart_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      csl_q     <= 1'b0;
      desc_wr_o <= 1'b0;
      stat_o    <= '0;
      abort_o   <= 1'b0;
    end else begin
      state_q   <= state_d;
      csl_q     <= csl_d;
      desc_wr_o <= close_c;
      stat_o    <= stat_c;
      abort_o   <= fatal_c;
    end
  end

  assign byte_inc_o      = byte_tick_i & ((state_q == ST_SEND) | (state_q == ST_JAM));
  assign hb_inc_o        = (state_q == ST_HBW);
  assign hb_clr_o        = (state_q != ST_HBW);
  assign evt_set_o       = close_c & (|stat_c);
  assign force_bad_crc_o = (state_q == ST_JAM);
  assign halted_o        = (state_q == ST_HALT);
endmodule

// File: rtl/eth_tx_err_sup.sv
module eth_tx_err_sup
  import eth_txs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RETRY_W   = 4,
  parameter int HB_WIN    = 20,
  parameter int JAM_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_active_i,
  input  logic               byte_tick_i,
  input  logic               fifo_empty_i,
  input  logic               crs_i,
  input  logic               col_i,
  input  logic [RETRY_W-1:0] retry_cnt_i,
  input  logic [RETRY_W-1:0] retry_lim_i,
  input  logic [CNT_W-1:0]   late_win_i,
  input  logic               hb_en_i,
  input  logic               restart_i,
  input  logic               evt_clr_i,
  input  logic               evt_mask_i,
  output logic               force_bad_crc_o,
  output logic               abort_o,
  output logic               desc_wr_o,
  output logic               desc_un_o,
  output logic               desc_csl_o,
  output logic               desc_rl_o,
  output logic               desc_lc_o,
  output logic               desc_hb_o,
  output logic               txe_evt_o,
  output logic               txe_irq_o,
  output logic               halted_o
);
  localparam int HB_W = $clog2(HB_WIN + 1);

  logic [CNT_W-1:0] byte_cnt;
  logic [HB_W-1:0]  hb_cnt;
  logic             byte_clr, byte_inc, hb_clr, hb_inc, evt_set;
  txs_stat_t        stat;

  eth_txs_cnt #(.W(CNT_W)) u_byte_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (byte_clr), .inc_i(byte_inc), .cnt_o(byte_cnt)
  );

  eth_txs_cnt #(.W(HB_W)) u_hb_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (hb_clr), .inc_i(hb_inc), .cnt_o(hb_cnt)
  );

  eth_txs_fsm #(
    .CNT_W(CNT_W), .RETRY_W(RETRY_W), .HB_WIN(HB_WIN), .JAM_BYTES(JAM_BYTES)
  ) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .tx_active_i     (tx_active_i),
    .byte_tick_i     (byte_tick_i),
    .fifo_empty_i    (fifo_empty_i),
    .crs_i           (crs_i),
    .col_i           (col_i),
    .retry_cnt_i     (retry_cnt_i),
    .retry_lim_i     (retry_lim_i),
    .late_win_i      (late_win_i),
    .hb_en_i         (hb_en_i),
    .restart_i       (restart_i),
    .byte_cnt_i      (byte_cnt),
    .hb_cnt_i        (hb_cnt),
    .byte_clr_o      (byte_clr),
    .byte_inc_o      (byte_inc),
    .hb_clr_o        (hb_clr),
    .hb_inc_o        (hb_inc),
    .force_bad_crc_o (force_bad_crc_o),
    .abort_o         (abort_o),
    .desc_wr_o       (desc_wr_o),
    .stat_o          (stat),
    .evt_set_o       (evt_set),
    .halted_o        (halted_o)
  );

  eth_txs_evt u_evt (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (evt_set), .clr_i(evt_clr_i), .mask_i(evt_mask_i),
    .evt_o (txe_evt_o), .irq_o(txe_irq_o)
  );

  assign desc_un_o  = stat.un;
  assign desc_csl_o = stat.csl;
  assign desc_rl_o  = stat.rl;
  assign desc_lc_o  = stat.lc;
  assign desc_hb_o  = stat.hb;
endmodule

// File: rtl/eth_txs_chk.sv
module eth_txs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_tick_i,
  input logic fifo_empty_i,
  input logic restart_i,
  input logic force_bad_crc_o,
  input logic abort_o,
  input logic desc_wr_o,
  input logic desc_un_o,
  input logic desc_csl_o,
  input logic desc_rl_o,
  input logic desc_lc_o,
  input logic desc_hb_o,
  input logic txe_evt_o,
  input logic txe_irq_o,
  input logic halted_o
);
  p_jam_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_bad_crc_o) |-> $past(byte_tick_i && fifo_empty_i));

  p_abort_fatal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (halted_o && desc_wr_o && (desc_un_o || desc_rl_o || desc_lc_o)));

  p_halt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !restart_i) |=> halted_o);

  p_no_wr_halted_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> !desc_wr_o);

  p_csl_soft_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_wr_o && desc_csl_o && !desc_lc_o && !desc_rl_o && !desc_un_o) |-> (!abort_o && !halted_o));

  p_fatal_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_un_o, desc_rl_o, desc_lc_o}));

  p_hb_soft_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_wr_o && desc_hb_o) |-> !abort_o);

  p_evt_on_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_wr_o && (desc_un_o || desc_csl_o || desc_rl_o || desc_lc_o || desc_hb_o)) |-> txe_evt_o);

  p_irq_needs_evt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txe_irq_o |-> txe_evt_o);
endmodule

bind eth_tx_err_sup eth_txs_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .byte_tick_i     (byte_tick_i),
  .fifo_empty_i    (fifo_empty_i),
  .restart_i       (restart_i),
  .force_bad_crc_o (force_bad_crc_o),
  .abort_o         (abort_o),
  .desc_wr_o       (desc_wr_o),
  .desc_un_o       (desc_un_o),
  .desc_csl_o      (desc_csl_o),
  .desc_rl_o       (desc_rl_o),
  .desc_lc_o       (desc_lc_o),
  .desc_hb_o       (desc_hb_o),
  .txe_evt_o       (txe_evt_o),
  .txe_irq_o       (txe_irq_o),
  .halted_o        (halted_o)
);

// File: tb/tb_eth_tx_err_sup.sv
`timescale 1ns/1ps
module tb_eth_tx_err_sup;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_active_i = 0, byte_tick_i = 0, fifo_empty_i = 0;
  logic       crs_i = 1, col_i = 0, hb_en_i = 0, restart_i = 0;
  logic       evt_clr_i = 0, evt_mask_i = 1;
  logic [3:0] retry_cnt_i = 4'd0, retry_lim_i = 4'd15;
  logic [7:0] late_win_i = 8'd64;
  logic force_bad_crc_o, abort_o, desc_wr_o, desc_un_o, desc_csl_o;
  logic desc_rl_o, desc_lc_o, desc_hb_o, txe_evt_o, txe_irq_o, halted_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  eth_tx_err_sup dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tk();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic start_frame();
    tx_active_i = 1; crs_i = 1; tk();
  endtask

  task automatic bytes(int n);
    for (int i = 0; i < n; i++) begin byte_tick_i = 1; tk(); end
    byte_tick_i = 0;
  endtask

  task automatic do_restart();
    tx_active_i = 0; restart_i = 1; evt_clr_i = 1; tk();
    restart_i = 0; evt_clr_i = 0;
  endtask

  // {un,csl,rl,lc,hb}
  function automatic logic [4:0] st();
    return {desc_un_o, desc_csl_o, desc_rl_o, desc_lc_o, desc_hb_o};
  endfunction

  task automatic t_reset();
    chk("R1 reset desc_wr", desc_wr_o, 0);
    chk("R3 reset halted", halted_o, 0);
    chk("R2 reset force", force_bad_crc_o, 0);
    chk("R10 reset evt", txe_evt_o, 0);
  endtask

  task automatic t_normal();
    start_frame(); bytes(3);
    tx_active_i = 0; tk();
    chk("R1 close wr", desc_wr_o, 1);
    chk("R1 close stat", st(), 0);
    chk("R1 no evt", txe_evt_o, 0);
    tk();
    chk("R1 single pulse", desc_wr_o, 0);
  endtask

  task automatic t_csl();
    start_frame(); bytes(2);
    crs_i = 0; bytes(1); crs_i = 1;
    tx_active_i = 0; tk();
    chk("R4 wr", desc_wr_o, 1);
    chk("R4 stat csl", st(), 5'b01000);
    chk("R4 no abort", abort_o, 0);
    chk("R4 not halted", halted_o, 0);
    chk("R4 evt", txe_evt_o, 1);
    chk("R11 irq mask1", txe_irq_o, 1);
    evt_clr_i = 1; tk(); evt_clr_i = 0;
    chk("R10 cleared", txe_evt_o, 0);
    chk("R11 irq off", txe_irq_o, 0);
  endtask

  task automatic t_underrun();
    start_frame(); bytes(3);
    fifo_empty_i = 1; byte_tick_i = 1; tk(); byte_tick_i = 0;
    chk("R2 force rise", force_bad_crc_o, 1);
    bytes(3);
    chk("R2 force after 3", force_bad_crc_o, 1);
    chk("R2 no early close", desc_wr_o, 0);
    byte_tick_i = 1; tk(); byte_tick_i = 0; fifo_empty_i = 0;
    chk("R2 wr", desc_wr_o, 1);
    chk("R2 stat un", st(), 5'b10000);
    chk("R2 abort", abort_o, 1);
    chk("R2 force end", force_bad_crc_o, 0);
    chk("R3 halted", halted_o, 1);
    chk("R2 evt", txe_evt_o, 1);
    tx_active_i = 0; tk();
    start_frame(); bytes(2); tx_active_i = 0; tk();
    chk("R3 halted no wr", desc_wr_o, 0);
    tk();
    chk("R3 still no wr", desc_wr_o, 0);
    chk("R3 still halted", halted_o, 1);
    do_restart();
    chk("R3 restart clears", halted_o, 0);
  endtask

  task automatic t_late();
    late_win_i = 8'd8;
    start_frame(); bytes(8);
    col_i = 1; tk(); col_i = 0;
    chk("R7 wr", desc_wr_o, 1);
    chk("R7 stat lc", st(), 5'b00010);
    chk("R7 abort", abort_o, 1);
    chk("R7 halted", halted_o, 1);
    do_restart();
  endtask

  task automatic t_retry_ok();
    late_win_i = 8'd8; retry_cnt_i = 4'd3;
    start_frame(); bytes(7);
    col_i = 1; tk(); col_i = 0;
    chk("R5/R7 edge no wr", desc_wr_o, 0);
    chk("R5 no abort", abort_o, 0);
    chk("R5 not halted", halted_o, 0);
    tx_active_i = 0; tk();
    chk("R5 no wr after end", desc_wr_o, 0);
    start_frame(); bytes(2); tx_active_i = 0; tk();
    chk("R5 retry closes", desc_wr_o, 1);
    chk("R5 retry stat", st(), 0);
  endtask

  task automatic t_retry_lim();
    late_win_i = 8'd64; retry_cnt_i = 4'd15; retry_lim_i = 4'd15;
    start_frame(); bytes(2);
    col_i = 1; tk(); col_i = 0;
    chk("R6 wr", desc_wr_o, 1);
    chk("R6 stat rl", st(), 5'b00100);
    chk("R6 abort", abort_o, 1);
    chk("R6 evt", txe_evt_o, 1);
    do_restart();
    retry_cnt_i = 4'd0;
  endtask

  task automatic t_hb_ok();
    hb_en_i = 1;
    start_frame(); bytes(2); tx_active_i = 0; tk();
    chk("R8 no wr at end", desc_wr_o, 0);
    repeat (4) tk();
    col_i = 1; tk(); col_i = 0;
    chk("R8 wr", desc_wr_o, 1);
    chk("R8 stat", st(), 0);
    chk("R8 no abort", abort_o, 0);
    start_frame(); bytes(2); tx_active_i = 0; tk();
    repeat (19) tk();
    chk("R8 edge not yet", desc_wr_o, 0);
    col_i = 1; tk(); col_i = 0;
    chk("R8 last cycle ok", desc_wr_o, 1);
    chk("R8 last cycle hb0", desc_hb_o, 0);
  endtask

  task automatic t_hb_miss();
    start_frame(); bytes(2); tx_active_i = 0; tk();
    repeat (19) tk();
    chk("R9 not yet", desc_wr_o, 0);
    tk();
    chk("R9 wr", desc_wr_o, 1);
    chk("R9 stat hb", st(), 5'b00001);
    chk("R9 evt", txe_evt_o, 1);
    chk("R9 not halted", halted_o, 0);
    hb_en_i = 0;
  endtask

  task automatic t_evt_race();
    evt_mask_i = 0; tk();
    chk("R11 masked", txe_irq_o, 0);
    chk("R10 sticky", txe_evt_o, 1);
    evt_mask_i = 1;
    start_frame(); crs_i = 0; bytes(1); crs_i = 1;
    tx_active_i = 0; evt_clr_i = 1; tk(); evt_clr_i = 0;
    chk("R10 set wins", txe_evt_o, 1);
    evt_clr_i = 1; tk(); evt_clr_i = 0;
    chk("R10 clear alone", txe_evt_o, 0);
  endtask

  initial begin
    repeat (3) tk();
    rst_ni = 1; tk();
    t_reset();
    t_normal();
    t_csl();
    t_underrun();
    t_late();
    t_retry_ok();
    t_retry_lim();
    t_hb_ok();
    t_hb_miss();
    t_evt_race();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule